// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM built so that the shared data path never needs an idle turnaround cycle between reads and writes. Its array holds 256 words of 36 bits, split into four 9-bit byte lanes. Commands are registered on rising clock edges. A write command does not carry its data. The data comes one or two enabled edges later, and the delay always equals the read latency of the selected timing mode. Because of this, read and write commands can alternate on every edge.

A static mode input chooses between two timings. Pipelined timing registers the read data in an output stage, and write data follows two edges after its command. Flow-through timing presents read data straight from the array once the address edge has passed, and write data follows one edge after its command. A 2-bit burst counter lets later edges continue an access without a new address. The burst order is linear or interleaved. When a read hits an address whose write is still waiting for its data, the read gets that newest data, merged per lane.

Top module: `lw_sram`

## Requirements
- R1: When `cke_n` is high at an edge, that edge is ignored: no command is accepted, no write is committed, no internal state moves, and `dout` and `dout_valid` hold their values. All latencies below count enabled edges only.
- R2: The block is selected only when `cs1_n` is low, `cs2` is high and `cs3_n` is low. On an enabled edge with any enable inactive, no access is started and the array is left unchanged.
- R3: A selected edge with `adv` low loads `addr` and starts a new access (`we_n` high for a read, low for a write). A selected edge with `adv` high continues the current burst only if an access has been loaded since the last deselect. Otherwise it counts as a deselect.
- R4: In pipelined mode (`flow` = 0), a read accepted at edge N drives its word on `dout` with `dout_valid` high after edge N+1.
- R5: For a write, `be_n[k]` low writes bits [9k+8:9k] of the word. Any combination of the four lanes may be written, and unselected lanes keep their old content.
- R6: A write with all four `be_n` bits high is a no-op and leaves the array unchanged.
- R7: In pipelined mode, the data of a write accepted at edge N is taken from `din` at edge N+2.
- R8: In flow-through mode (`flow` = 1), a read accepted at edge N drives `dout` with `dout_valid` high right after edge N.
- R9: In flow-through mode, the data of a write accepted at edge N is taken from `din` at edge N+1.
- R10: With `burst_ilv` = 0, continuation beat k (k = 1, 2, 3, then wrapping) uses low address bits (start + k) mod 4 and keeps the upper address bits. Each beat repeats the operation type of the load and takes `be_n` from its own edge.
- R11: With `burst_ilv` = 1, continuation beat k uses low address bits start XOR (k mod 4). Otherwise it behaves as in R10.
- R12: A read always returns the newest data for its address, including a write whose data is still due. Reads and writes may alternate on consecutive edges.
- R13: A low `rst_n` at an edge clears the command pipeline, the burst state and `dout_valid`, and in pipelined mode `dout` reads zero. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Low: load new address; high: continue burst |
| we_n | input | 1 | Low: write, high: read |
| be_n | input | 4 | Per-lane write enables, active low |
| addr | input | 8 | Word address |
| din | input | 36 | Late write data |
| flow | input | 1 | Static mode: 0 pipelined, 1 flow-through |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| dout | output | 36 | Read data |
| dout_valid | output | 1 | High while `dout` carries a read result |

## Verification
The assertions check the per-cycle rules: a disabled clock freezes the outputs, a deselect produces no result, a read raises `dout_valid` after the latency of its mode, and every array write can be traced back to a write command exactly one or two enabled edges earlier. Other behaviour needs data to be tracked across many cycles, so only the bench scenarios can show it. This covers the merging of lanes, the no-op write, the addresses of linear and interleaved bursts, forwarding of data that is still due, and the array surviving a reset. The bench sweeps every address, all sixteen lane masks and every burst start in both modes, and compares each result with a reference memory that it keeps itself.

// File: rtl/lw_sram_pkg.sv
// Shared types for the late-write SRAM model.
// Assumes: nothing beyond the standard language.
package lw_sram_pkg;
    // Kind of access held in one command stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
// Command decoder and burst address generator.
// Turns the pins of one edge into a single access (kind, address, lane mask).
// Assumes: en is the active-high clock enable, and burst_ilv only changes
// between bursts.
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_ilv,
    output op_e               op,
    output logic [ADDR_W-1:0] op_addr,
    output logic [LANES-1:0]  op_lanes
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic               run_q;
    logic               wr_q;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;

    logic               sel;
    logic               load;
    logic               cont;
    logic [BURST_W-1:0] nxt;
    logic [BURST_W-1:0] low;
    logic [HI_W-1:0]    hi;

    // Decode selection and the next burst offset.
    always_comb begin
        sel  = !cs1_n && cs2 && !cs3_n;
        load = sel && !adv;
        cont = sel && adv && run_q;
        nxt  = cnt_q + 1'b1;
        hi   = base_q[ADDR_W-1:BURST_W];
        if (burst_ilv) begin
            low = base_q[BURST_W-1:0] ^ nxt;
        end else begin
            low = base_q[BURST_W-1:0] + nxt;
        end
    end

    // Form the access presented at this edge.
    always_comb begin
        op      = OP_IDLE;
        op_addr = addr;
        if (load) begin
            op = we_n ? OP_READ : OP_WRITE;
        end else if (cont) begin
            op      = wr_q ? OP_WRITE : OP_READ;
            op_addr = {hi, low};
        end
        op_lanes = (op == OP_WRITE) ? ~be_n : '0;
    end

    // Track burst state across enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wr_q   <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                run_q  <= 1'b1;
                wr_q   <= !we_n;
                base_q <= addr;
                cnt_q  <= '0;
            end else if (cont) begin
                cnt_q  <= nxt;
            end else begin
                run_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lw_sram_pipe.sv
// Command delay line: stage 0 holds the access of the last enabled edge,
// stage g holds the one of g edges before that.
// Assumes: en gates every shift.
module lw_sram_pipe
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  op_e               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_lanes,
    output op_e               st_op    [DEPTH],
    output logic [ADDR_W-1:0] st_addr  [DEPTH],
    output logic [LANES-1:0]  st_lanes [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        op_e               op_q;
        logic [ADDR_W-1:0] addr_q;
        logic [LANES-1:0]  lanes_q;
        op_e               src_op;
        logic [ADDR_W-1:0] src_addr;
        logic [LANES-1:0]  src_lanes;

        if (g == 0) begin : g_head
            // The first stage is fed by the decoder.
            always_comb begin
                src_op    = in_op;
                src_addr  = in_addr;
                src_lanes = in_lanes;
            end
        end else begin : g_tail
            // Later stages are fed by the stage before them.
            always_comb begin
                src_op    = st_op[g-1];
                src_addr  = st_addr[g-1];
                src_lanes = st_lanes[g-1];
            end
        end

        // Advance this stage on an enabled edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_q    <= OP_IDLE;
                addr_q  <= '0;
                lanes_q <= '0;
            end else if (en) begin
                op_q    <= src_op;
                addr_q  <= src_addr;
                lanes_q <= src_lanes;
            end
        end

        assign st_op[g]    = op_q;
        assign st_addr[g]  = addr_q;
        assign st_lanes[g] = lanes_q;
    end
endmodule

// File: rtl/lw_sram_array.sv
// Word array with per-lane write strobes and an asynchronous read port.
// Assumes: contents are not reset; wr_en already includes the clock enable.
module lw_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [LANES-1:0][LANE_W-1:0] mem_q [WORDS];

    // Store the enabled lanes of a committed write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) begin
                    mem_q[wr_addr][l] <= wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/lw_sram.sv
// Late-write synchronous SRAM, top level.
// Decodes commands, delays writes until their data is due, commits them to
// the array, and returns reads with the latency of the selected mode.
// Pipelined reads forward lanes of a write whose data arrives on the same edge.
// Assumes: flow and burst_ilv are static while accesses are in flight.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [LANES-1:0]        be_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic                    flow,
    input  logic                    burst_ilv,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_valid
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 2;

    logic              en;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_lanes;
    logic              cmd_is_wr;

    op_e               st_op    [DEPTH];
    logic [ADDR_W-1:0] st_addr  [DEPTH];
    logic [LANES-1:0]  st_lanes [DEPTH];

    op_e               cm_op;
    logic [ADDR_W-1:0] cm_addr;
    logic [LANES-1:0]  cm_lanes;
    logic              wr_strobe;

    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] merged;
    logic              fwd_hit;
    logic              s1_rd;

    logic [DATA_W-1:0] out_q;
    logic              out_v_q;

    assign en        = !cke_n;
    assign cmd_is_wr = (cmd_op == OP_WRITE);

    lw_sram_cmd #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .BURST_W(2)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cs1_n    (cs1_n),
        .cs2      (cs2),
        .cs3_n    (cs3_n),
        .adv      (adv),
        .we_n     (we_n),
        .be_n     (be_n),
        .addr     (addr),
        .burst_ilv(burst_ilv),
        .op       (cmd_op),
        .op_addr  (cmd_addr),
        .op_lanes (cmd_lanes)
    );

    lw_sram_pipe #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .in_op   (cmd_op),
        .in_addr (cmd_addr),
        .in_lanes(cmd_lanes),
        .st_op   (st_op),
        .st_addr (st_addr),
        .st_lanes(st_lanes)
    );

    // Pick the stage whose write data is on din at this edge.
    always_comb begin
        if (flow) begin
            cm_op    = st_op[0];
            cm_addr  = st_addr[0];
            cm_lanes = st_lanes[0];
        end else begin
            cm_op    = st_op[DEPTH-1];
            cm_addr  = st_addr[DEPTH-1];
            cm_lanes = st_lanes[DEPTH-1];
        end
        wr_strobe = en && (cm_op == OP_WRITE) && (|cm_lanes);
    end

    lw_sram_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_strobe),
        .wr_addr (cm_addr),
        .wr_lanes(cm_lanes),
        .wr_data (din),
        .rd_addr (st_addr[0]),
        .rd_data (rd_data)
    );

    // Detect a pipelined read that collides with the write committing now.
    always_comb begin
        s1_rd   = (st_op[0] == OP_READ);
        fwd_hit = !flow && s1_rd && (st_op[DEPTH-1] == OP_WRITE)
                  && (st_addr[DEPTH-1] == st_addr[0]);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Take a lane from din when the colliding write updates it.
        assign merged[l*LANE_W +: LANE_W] =
            (fwd_hit && st_lanes[DEPTH-1][l]) ? din[l*LANE_W +: LANE_W]
                                              : rd_data[l*LANE_W +: LANE_W];
    end

    // Pipelined output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_v_q <= 1'b0;
        end else if (en) begin
            out_v_q <= s1_rd;
            if (s1_rd) begin
                out_q <= merged;
            end
        end
    end

    assign dout       = flow ? rd_data : out_q;
    assign dout_valid = flow ? s1_rd : out_v_q;
endmodule

// File: rtl/lw_sram_chk.sv
// Protocol checker for lw_sram, attached by bind.
// Assumes: flow changes only while rst_n is low.
module lw_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              adv,
    input logic              we_n,
    input logic              flow,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              wr_strobe,
    input logic              cmd_wr
);
    logic sel;
    assign sel = !cs1_n && cs2 && !cs3_n;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cke_n) && $stable(flow)
        |-> $stable(dout) && $stable(dout_valid));

    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flow && !cke_n && !sel |=> !dout_valid);

    p_pipe_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flow && !cke_n && sel && !adv && we_n ##1 !cke_n |=> dout_valid);

    p_flow_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flow && !cke_n && sel && !adv && we_n |=> dout_valid);

    p_pipe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flow && wr_strobe && $past(rst_n) && $past(rst_n, 2)
        && !$past(cke_n) && !$past(cke_n, 2) |-> $past(cmd_wr, 2));

    p_flow_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flow && wr_strobe && $past(rst_n) && !$past(cke_n)
        |-> $past(cmd_wr));
endmodule

bind lw_sram lw_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .cs3_n     (cs3_n),
    .adv       (adv),
    .we_n      (we_n),
    .flow      (flow),
    .dout      (dout),
    .dout_valid(dout_valid),
    .wr_strobe (wr_strobe),
    .cmd_wr    (cmd_is_wr)
);

// File: tb/lw_sram_bench.sv
// Self-checking bench for lw_sram with a reference memory model.
module lw_sram_bench;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          cs1_n = 1'b1;
    logic          cs2 = 1'b1;
    logic          cs3_n = 1'b0;
    logic          adv = 1'b0;
    logic          we_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic [7:0]    addr = '0;
    logic [DW-1:0] din = '0;
    logic          flow = 1'b0;
    logic          ilv = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_valid;

    always #2 clk = ~clk;

    lw_sram u_lw_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .adv(adv), .we_n(we_n), .be_n(be_n), .addr(addr),
        .din(din), .flow(flow), .burst_ilv(ilv), .dout(dout),
        .dout_valid(dout_valid)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ph = 1;
    int cyc = 0;

    // Reference state.
    logic [DW-1:0] mref [256];
    logic          sv [2];
    logic [7:0]    sa [2];
    logic [3:0]    sb [2];
    int            sp [2];
    logic          rp_v, exp_v, b_run, b_wr;
    logic [7:0]    rp_a, b_base;
    logic [1:0]    b_cnt;
    logic [DW-1:0] exp_d;

    function automatic logic [DW-1:0] gen(input logic [7:0] a, input int p);
        return {4'(p), a, 24'(a * 97 + p * 4099)};
    endfunction

    task automatic chk(input string tag, input logic ok,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick(input logic c_n, input logic s1n, input logic s2v,
                        input logic s3n, input logic av, input logic wn,
                        input logic [3:0] ben, input logic [7:0] ad,
                        input string tag);
        logic [DW-1:0] hold_d;
        logic          hold_v, sel, ld, ct;
        logic [1:0]    nx, lo;
        logic [7:0]    oa;
        int            op, due;
        hold_d = dout;
        hold_v = dout_valid;
        due = flow ? 0 : 1;
        cke_n = c_n; cs1_n = s1n; cs2 = s2v; cs3_n = s3n;
        adv = av; we_n = wn; be_n = ben; addr = ad;
        din = sv[due] ? gen(sa[due], sp[due]) : {4'hF, 32'(cyc * 7919)};
        if (!c_n) begin
            sel = !s1n && s2v && !s3n;
            ld = sel && !av;
            ct = sel && av && b_run;
            nx = b_cnt + 2'd1;
            lo = ilv ? (b_base[1:0] ^ nx) : (b_base[1:0] + nx);
            op = 0;
            oa = ad;
            if (ld) op = wn ? 1 : 2;
            else if (ct) begin
                op = b_wr ? 2 : 1;
                oa = {b_base[7:2], lo};
            end
            if (sv[due])
                for (int l = 0; l < 4; l++)
                    if (sb[due][l]) mref[sa[due]][l*9 +: 9] = din[l*9 +: 9];
            if (flow) begin
                exp_v = (op == 1);
                if (op == 1) exp_d = mref[oa];
            end else begin
                exp_v = rp_v;
                if (rp_v) exp_d = mref[rp_a];
                rp_v = (op == 1);
                rp_a = oa;
            end
            sv[1] = sv[0]; sa[1] = sa[0]; sb[1] = sb[0]; sp[1] = sp[0];
            sv[0] = (op == 2); sa[0] = oa; sb[0] = ~ben; sp[0] = ph;
            if (op == 2) ph++;
            if (ld) begin
                b_run = 1'b1; b_wr = !wn; b_base = ad; b_cnt = 2'd0;
            end else if (ct) b_cnt = nx;
            else b_run = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (c_n) begin
            chk("R1 hold dout", dout === hold_d, dout, hold_d);
            chk("R1 hold valid", dout_valid === hold_v, 36'(dout_valid), 36'(hold_v));
        end else begin
            chk({tag, " valid"}, dout_valid === exp_v, 36'(dout_valid), 36'(exp_v));
            if (exp_v) chk({tag, " data"}, dout === exp_d, dout, exp_d);
        end
    endtask

    task automatic idle(input string tag);
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'h00, tag);
    endtask
    task automatic rd(input logic [7:0] a, input string tag);
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [3:0] ben, input string tag);
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ben, a, tag);
    endtask
    task automatic beat(input logic [3:0] ben, input string tag);
        tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ben, 8'h00, tag);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        flow = m;
        cke_n = 1'b0; cs1_n = 1'b1; adv = 1'b0; we_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R13 reset valid", dout_valid === 1'b0, 36'(dout_valid), 36'd0);
        if (!m) chk("R13 reset dout", dout === '0, dout, '0);
        rst_n = 1'b1;
        sv[0] = 1'b0; sv[1] = 1'b0;
        rp_v = 1'b0; exp_v = 1'b0; b_run = 1'b0; b_wr = 1'b0;
        b_base = '0; b_cnt = '0;
    endtask

    initial begin : watchdog
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mref[i] = '0;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            do_reset(1'(m));
            // Full sweep: write every word, then read it back.
            for (int a = 0; a < 256; a++) wr(8'(a), 4'h0, m ? "R9" : "R7");
            for (int k = 0; k < 3; k++) idle("R7");
            for (int a = 0; a < 256; a++) rd(8'(a), m ? "R8" : "R4");
            for (int k = 0; k < 3; k++) idle("R4");
            // Every lane mask, each read back right after its write.
            for (int p = 0; p < 16; p++) begin
                wr(8'(p), 4'(p), p == 15 ? "R6" : "R5");
                rd(8'(p), p == 15 ? "R6" : "R5");
            end
            for (int k = 0; k < 3; k++) idle("R5");
            // Reads and writes alternating with no gap, hitting pending data.
            for (int i = 0; i < 24; i++) begin
                wr(8'(64 + i), 4'(i * 5), "R12");
                rd(8'(64 + i), "R12");
                rd(8'(64 + (i ^ 1)), "R12");
            end
            for (int k = 0; k < 3; k++) idle("R12");
            // Each chip enable alone deselects.
            tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd20, "R2");
            tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd20, "R2");
            tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'd20, "R2");
            for (int k = 0; k < 3; k++) idle("R2");
            rd(8'd20, "R2");
            for (int k = 0; k < 3; k++) idle("R2");
            // Disabled clock: write command ignored, pending write and output held.
            wr(8'd30, 4'h0, "R1");
            tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd31, "R1");
            tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd31, "R1");
            for (int k = 0; k < 3; k++) idle("R1");
            rd(8'd30, "R1");
            rd(8'd31, "R1");
            tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd32, "R1");
            tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd32, "R1");
            for (int k = 0; k < 3; k++) idle("R1");
            // Bursts in both orders from every start offset, with wrap.
            for (int o = 0; o < 2; o++) begin
                ilv = 1'(o);
                for (int s = 0; s < 4; s++) begin
                    wr(8'(128 + 8 * s + s), 4'h0, o ? "R11" : "R10");
                    for (int b = 0; b < 4; b++) beat(4'(b * 3), o ? "R11" : "R10");
                    for (int k = 0; k < 3; k++) idle("R10");
                    rd(8'(128 + 8 * s + s), o ? "R11" : "R10");
                    for (int b = 0; b < 4; b++) beat(4'hF, o ? "R11" : "R10");
                    for (int k = 0; k < 3; k++) idle("R10");
                    for (int a = 0; a < 4; a++) rd(8'(128 + 8 * s + a), "R10");
                    for (int k = 0; k < 3; k++) idle("R10");
                end
            end
            ilv = 1'b0;
            // Continuation after a deselect is itself a deselect.
            rd(8'h50, "R3");
            idle("R3");
            tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, "R3");
            for (int k = 0; k < 3; k++) idle("R3");
            for (int a = 0; a < 4; a++) rd(8'(8'h50 + a), "R3");
            for (int k = 0; k < 3; k++) idle("R3");
        end
        // Array contents survive reset.
        do_reset(1'b0);
        rd(8'd200, "R13");
        idle("R13");
        idle("R13");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule